// File: doc/BRIEF.md
# Tamper Response Memory-Clear Sequencer

This controller reacts to a tamper alarm by holding every system domain in reset and then wiping each on-chip memory instance. The alarm is active low and is first taken into the local clock domain through a flop synchronizer. It counts only once the configuration-done qualifier is high. Each memory has a request line and an acknowledge line. A fuse-derived policy bit chooses whether all memories wipe together or strictly one after another, which limits the current drawn at any moment. Once every memory has acknowledged, the block signals that the tamper has been handled. It then parks in a terminal state that only power-on reset can leave.

The same clearing machinery also serves ordinary cold and warm resets, when the matching policy bit is set. In that case the block returns to idle after the wipe and does not signal a tamper. A tamper alarm that arrives during such an ordinary wipe takes over and restarts the whole sequence as a tamper response. A phase output exposes the sequencer's current step.

Top module: `tamper_wipe_seq`

## Requirements
- R1: `tamper_n` is active low (1 = no alarm). It passes through a two-stage synchronizer. A low level that becomes visible before a rising edge moves `phase` from idle to reset-assert on the third rising edge.
- R2: While `cfg_done` is 0, a low `tamper_n` has no effect, and `phase` stays idle.
- R3: A response first spends at least one cycle in reset-assert with `dom_rst` high and no clear request, then moves to clearing. `dom_rst` stays high while any request is active.
- R4: With `pol_serial` = 0, every bit of `clr_req` rises in the first clearing cycle. Each bit stays high until its own `clr_ack` bit is seen.
- R5: With `pol_serial` = 1, at most one `clr_req` bit is high at a time. Memories are served in ascending index order, starting from index 0.
- R6: The clearing phase ends only after all N memories have acknowledged. The phase that follows is done (code 3), and in a tamper response `tamper_handled` is 1 in that phase.
- R7: After a tamper response the block enters dead (code 4) and stays there with `tamper_handled` and `dom_rst` high. Cold requests, warm requests and tamper input are all ignored in dead. Only `por_n` low returns it to idle.
- R8: In idle, a `cold_rst_req` pulse starts a wipe only when `pol_clr_cold` = 1, and a `warm_rst_req` pulse only when `pol_clr_warm` = 1. Such a wipe goes done to idle and never raises `tamper_handled`.
- R9: A qualified tamper alarm during an ordinary wipe returns `phase` to reset-assert. The wipe then restarts from scratch as a tamper response.
- R10: The `phase` codes are: idle 0, reset-assert 1, clearing 2, done 3, dead 4. After reset, `phase` is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cold_rst_req | input | 1 | Ordinary cold reset request pulse |
| warm_rst_req | input | 1 | Ordinary warm reset request pulse |
| tamper_n | input | 1 | Tamper alarm, active low, asynchronous |
| cfg_done | input | 1 | Configuration complete; qualifies the alarm |
| pol_serial | input | 1 | 1 = clear one memory at a time, 0 = all at once |
| pol_clr_cold | input | 1 | Wipe memories on an ordinary cold reset |
| pol_clr_warm | input | 1 | Wipe memories on an ordinary warm reset |
| clr_ack | input | N | Per-memory clear-complete acknowledge |
| dom_rst | output | 1 | Hold all system domains in reset |
| clr_req | output | N | Per-memory clear request, held until acknowledged |
| tamper_handled | output | 1 | Tamper response finished |
| phase | output | 3 | Current sequencer phase code |

## Verification
On every cycle, the assertions check the following:
- idle is held while the qualifier is low;
- requests occur only in clearing, and always under domain reset;
- series mode never has more than one request;
- the handled flag appears only in done or dead;
- dead is never left;
- an ordinary wipe returns to idle.

Some behaviour can only be shown by the bench scenarios, which drive acknowledge responders with varied latencies. These are:
- the exact three-edge synchronizer latency;
- ascending service order;
- the count of N acknowledges before done;
- the policy-bit decode for cold and warm requests;
- the restart from index 0 after a tamper preempts an ordinary wipe.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RSTA  = 3'd1,
        PH_CLEAR = 3'd2,
        PH_DONE  = 3'd3,
        PH_DEAD  = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   tmp;    // current run is a tamper response
    } fsm_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tws_clear_engine.sv
module tws_clear_engine #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         abort,
    input  logic         serial,
    input  logic [N-1:0] ack,
    output logic [N-1:0] req,
    output logic         all_done
);
    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};
    localparam logic [N-1:0] ONE      = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] pend_d, pend_q;
    logic [N-1:0] lowest;

    always_comb begin
        pend_d = pend_q;
        if (abort)     pend_d = '0;
        else if (load) pend_d = ALL_ONES;
        else           pend_d = pend_q & ~(ack & req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // isolate lowest pending memory for series mode
    assign lowest = pend_q & (~pend_q + ONE);

    for (genvar i = 0; i < N; i++) begin : g_req
        assign req[i] = serial ? lowest[i] : pend_q[i];
    end

    assign all_done = ~|pend_q;
endmodule

// File: rtl/tamper_wipe_seq.sv
module tamper_wipe_seq
    import tws_pkg::*;
#(
    parameter int N           = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         cold_rst_req,
    input  logic         warm_rst_req,
    input  logic         tamper_n,
    input  logic         cfg_done,
    input  logic         pol_serial,
    input  logic         pol_clr_cold,
    input  logic         pol_clr_warm,
    input  logic [N-1:0] clr_ack,
    output logic         dom_rst,
    output logic [N-1:0] clr_req,
    output logic         tamper_handled,
    output logic [2:0]   phase
);
    fsm_t st_d, st_q;
    logic tamper_sync;
    logic tamper_evt;
    logic ordinary_evt;
    logic load, abort, all_done;

    tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (tamper_n),
        .q     (tamper_sync)
    );

    tws_clear_engine #(.N(N)) u_engine (
        .clk      (clk),
        .rst_n    (por_n),
        .load     (load),
        .abort    (abort),
        .serial   (pol_serial),
        .ack      (clr_ack),
        .req      (clr_req),
        .all_done (all_done)
    );

    assign tamper_evt   = cfg_done & ~tamper_sync;
    assign ordinary_evt = (cold_rst_req & pol_clr_cold) | (warm_rst_req & pol_clr_warm);

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        abort = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (tamper_evt) begin
                    st_d.ph  = PH_RSTA;
                    st_d.tmp = 1'b1;
                end else if (ordinary_evt) begin
                    st_d.ph  = PH_RSTA;
                    st_d.tmp = 1'b0;
                end
            end
            PH_RSTA: begin
                if (!st_q.tmp && tamper_evt) begin
                    st_d.tmp = 1'b1;
                end else begin
                    st_d.ph = PH_CLEAR;
                    load    = 1'b1;
                end
            end
            PH_CLEAR: begin
                if (!st_q.tmp && tamper_evt) begin
                    st_d.ph  = PH_RSTA;
                    st_d.tmp = 1'b1;
                    abort    = 1'b1;
                end else if (all_done) begin
                    st_d.ph = PH_DONE;
                end
            end
            PH_DONE: begin
                if (st_q.tmp) begin
                    st_d.ph = PH_DEAD;
                end else begin
                    st_d.ph  = PH_IDLE;
                    st_d.tmp = 1'b0;
                end
            end
            PH_DEAD: begin
                st_d = st_q;
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.tmp = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{ph: PH_IDLE, tmp: 1'b0};
        else        st_q <= st_d;
    end

    assign phase          = st_q.ph;
    assign dom_rst        = (st_q.ph != PH_IDLE);
    assign tamper_handled = st_q.tmp & ((st_q.ph == PH_DONE) | (st_q.ph == PH_DEAD));
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
    parameter int N = 11
) (
    input logic         clk,
    input logic         por_n,
    input logic         cold_rst_req,
    input logic         warm_rst_req,
    input logic         cfg_done,
    input logic         pol_serial,
    input logic         dom_rst,
    input logic [N-1:0] clr_req,
    input logic         tamper_handled,
    input logic [2:0]   phase
);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        (phase == 3'd0 && !cfg_done && !cold_rst_req && !warm_rst_req) |=> phase == 3'd0);

    p_req_under_reset_r3: assert property (@(posedge clk) disable iff (!por_n)
        (clr_req != '0) |-> dom_rst);

    p_rsta_exit_r3: assert property (@(posedge clk) disable iff (!por_n)
        (phase == 3'd1) |=> (phase == 3'd1 || phase == 3'd2));

    p_req_in_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
        (clr_req != '0) |-> phase == 3'd2);

    p_serial_single_r5: assert property (@(posedge clk) disable iff (!por_n)
        pol_serial |-> $onehot0(clr_req));

    p_handled_phase_r6: assert property (@(posedge clk) disable iff (!por_n)
        tamper_handled |-> (phase == 3'd3 || phase == 3'd4));

    p_dead_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        (phase == 3'd4) |=> (phase == 3'd4 && tamper_handled));

    p_ordinary_return_r8: assert property (@(posedge clk) disable iff (!por_n)
        (phase == 3'd3 && !tamper_handled) |=> phase == 3'd0);
endmodule

bind tamper_wipe_seq tws_checker #(.N(N)) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .cold_rst_req   (cold_rst_req),
    .warm_rst_req   (warm_rst_req),
    .cfg_done       (cfg_done),
    .pol_serial     (pol_serial),
    .dom_rst        (dom_rst),
    .clr_req        (clr_req),
    .tamper_handled (tamper_handled),
    .phase          (phase)
);

// File: tb/tamper_wipe_seq_tb.sv
`timescale 1ns/1ps
module tamper_wipe_seq_tb;
    localparam int N = 11;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    // {is_warm, pol_clr_cold, pol_clr_warm, pol_serial, expect_wipe}
    localparam logic [4:0] VEC [6] = '{
        5'b0_10_0_1,
        5'b0_01_0_0,
        5'b1_01_1_1,
        5'b1_10_0_0,
        5'b0_11_1_1,
        5'b1_11_0_1
    };

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic cold_rst_req = 1'b0, warm_rst_req = 1'b0;
    logic tamper_n = 1'b1, cfg_done = 1'b0;
    logic pol_serial = 1'b0, pol_clr_cold = 1'b0, pol_clr_warm = 1'b0;
    logic [N-1:0] clr_ack = '0;
    logic dom_rst, tamper_handled;
    logic [N-1:0] clr_req;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;
    int cnt [N];

    always #5 clk = ~clk;

    tamper_wipe_seq #(.N(N)) u_dut (
        .clk(clk), .por_n(por_n), .cold_rst_req(cold_rst_req), .warm_rst_req(warm_rst_req),
        .tamper_n(tamper_n), .cfg_done(cfg_done), .pol_serial(pol_serial),
        .pol_clr_cold(pol_clr_cold), .pol_clr_warm(pol_clr_warm), .clr_ack(clr_ack),
        .dom_rst(dom_rst), .clr_req(clr_req), .tamper_handled(tamper_handled), .phase(phase)
    );

    // memory responders: ack pulse after (i%3)+1 requested cycles
    initial for (int i = 0; i < N; i++) cnt[i] = 0;
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (clr_req[i] && !clr_ack[i]) begin
                if (cnt[i] >= i % 3) begin
                    clr_ack[i] <= 1'b1;
                    cnt[i] <= 0;
                end else begin
                    cnt[i] <= cnt[i] + 1;
                end
            end else begin
                clr_ack[i] <= 1'b0;
                cnt[i] <= 0;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        tick(2);
        por_n = 1'b1;
        tick(1);
    endtask

    // called at the first clearing negedge
    task automatic run_clear(input bit ser, input string rq);
        int acks = 0;
        int last = -1;
        int guard = 0;
        bit bad = 0;
        while (phase == 3'd2 && guard < 5000) begin
            if (ser && $countones(clr_req) > 1) bad = 1;
            if (ser && clr_req != '0) begin
                for (int i = 0; i < N; i++) begin
                    if (clr_req[i]) begin
                        if (i < last) bad = 1;
                        last = i;
                    end
                end
            end
            acks += $countones(clr_ack & clr_req);
            tick(1);
            guard++;
        end
        chk(!bad, ser ? "R5" : "R4", "service order / single request", int'(bad), 0);
        chk(acks == N, "R6", "acks before leaving clear", acks, N);
        chk(phase == 3'd3, "R6", "phase after clear", phase, 3);
        chk(clr_req == '0, rq, "requests after clear", clr_req, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        // reset state
        tick(2);
        por_n = 1'b1;
        tick(1);
        chk(phase == 3'd0, "R10", "phase after reset", phase, 0);
        chk(!dom_rst && !tamper_handled, "R10", "dom_rst|handled after reset", {dom_rst, tamper_handled}, 0);
        chk(clr_req == '0, "R10", "clr_req after reset", clr_req, 0);

        // alarm before configuration done is ignored
        tamper_n = 1'b0;
        tick(10);
        chk(phase == 3'd0, "R2", "phase with unqualified alarm", phase, 0);
        chk(!dom_rst, "R2", "dom_rst with unqualified alarm", dom_rst, 0);
        tamper_n = 1'b1;
        tick(4);
        cfg_done = 1'b1;
        tick(2);

        // table of ordinary reset scenarios
        for (int k = 0; k < 6; k++) begin
            pol_clr_cold = VEC[k][3];
            pol_clr_warm = VEC[k][2];
            pol_serial   = VEC[k][1];
            tick(1);
            if (VEC[k][4]) warm_rst_req = 1'b1; else cold_rst_req = 1'b1;
            tick(1);
            warm_rst_req = 1'b0;
            cold_rst_req = 1'b0;
            chk(phase == (VEC[k][0] ? 3'd1 : 3'd0), "R8", $sformatf("vector %0d start", k), phase, VEC[k][0] ? 1 : 0);
            if (VEC[k][0]) begin
                chk(dom_rst && clr_req == '0, "R3", "reset-assert step", {dom_rst, clr_req}, 1 << N);
                tick(1);
                chk(clr_req == (VEC[k][1] ? {{(N-1){1'b0}}, 1'b1} : ALL), VEC[k][1] ? "R5" : "R4",
                    "first clear requests", clr_req, VEC[k][1] ? 1 : int'(ALL));
                run_clear(VEC[k][1], "R6");
                chk(!tamper_handled, "R8", "no handled on ordinary wipe", tamper_handled, 0);
                tick(1);
                chk(phase == 3'd0, "R8", "return to idle", phase, 0);
            end else begin
                tick(3);
                chk(phase == 3'd0 && !dom_rst, "R8", "no wipe with policy off", phase, 0);
            end
        end

        // parallel tamper response
        pol_serial = 1'b0;
        tamper_n = 1'b0;
        tick(2);
        chk(phase == 3'd0, "R1", "phase two edges after alarm", phase, 0);
        tick(1);
        chk(phase == 3'd1, "R1", "phase three edges after alarm", phase, 1);
        chk(dom_rst, "R3", "dom_rst in reset-assert", dom_rst, 1);
        tick(1);
        chk(clr_req == ALL, "R4", "all requests together", clr_req, int'(ALL));
        run_clear(1'b0, "R4");
        chk(tamper_handled, "R6", "handled in done", tamper_handled, 1);
        tick(1);
        chk(phase == 3'd4, "R7", "dead after done", phase, 4);
        cold_rst_req = 1'b1;
        warm_rst_req = 1'b1;
        tamper_n = 1'b1;
        tick(3);
        cold_rst_req = 1'b0;
        warm_rst_req = 1'b0;
        tamper_n = 1'b0;
        tick(5);
        chk(phase == 3'd4 && tamper_handled && dom_rst, "R7", "dead holds under resets", phase, 4);
        tamper_n = 1'b1;
        do_por();
        chk(phase == 3'd0 && !tamper_handled, "R7", "power-on reset leaves dead", phase, 0);

        // serial tamper response
        pol_serial = 1'b1;
        tick(3);
        tamper_n = 1'b0;
        tick(3);
        chk(phase == 3'd1, "R1", "serial alarm latency", phase, 1);
        tick(1);
        chk(clr_req == {{(N-1){1'b0}}, 1'b1}, "R5", "first serial request is index 0", clr_req, 1);
        run_clear(1'b1, "R5");
        chk(tamper_handled, "R6", "handled after serial wipe", tamper_handled, 1);
        tamper_n = 1'b1;
        do_por();

        // tamper preempts an ordinary wipe
        pol_serial = 1'b1;
        pol_clr_cold = 1'b1;
        tick(3);
        cold_rst_req = 1'b1;
        tick(1);
        cold_rst_req = 1'b0;
        tick(6);
        chk(phase == 3'd2 && clr_req != {{(N-1){1'b0}}, 1'b1}, "R9", "ordinary wipe past index 0", clr_req, 0);
        tamper_n = 1'b0;
        tick(3);
        chk(phase == 3'd1, "R9", "preempted to reset-assert", phase, 1);
        tick(1);
        chk(clr_req == {{(N-1){1'b0}}, 1'b1}, "R9", "restart at index 0", clr_req, 1);
        run_clear(1'b1, "R9");
        chk(tamper_handled, "R9", "preempting wipe is a tamper response", tamper_handled, 1);
        tick(1);
        chk(phase == 3'd4, "R9", "dead after preempting wipe", phase, 4);

        summary();
    end
endmodule